// File: doc/BRIEF.md
# Burst-of-Two Separate-I/O Double-Rate SRAM

This block is a synthesizable on-chip memory with one write data bus and one read data bus. Each bus carries two beats per command, one on each half of the command clock. Commands arrive on rising command-clock edges. An active-low command strobe qualifies the slot, and a select bit chooses read or write. Each address names one word that is two beats wide. Beat 0 is the low half of the word and beat 1 is the high half.

Both halves of the command clock are modelled with a single clock running at twice the command rate and an internal phase bit. The whole design therefore sits in one clock domain. The block reports which fast edge is a command slot through `k_slot`.

Timing is counted in fast-clock edges, with the command slot at edge k:
- **Write:** the block takes beat 0 from `wdata` at edge k+2 and beat 1 at edge k+3.
- **Read:** the block drives beat 0 after edge k+3 and beat 1 after edge k+4.
- **Idle bus:** whenever `rvalid` is low, the read bus counts as floating.

Top module: `ddr_sio_b2`

## Requirements
- R1: When `cmd_n` is 1 at a command slot, the slot is idle. `is_read`, `addr` and `wdata` have no effect: no beat appears on the read bus for it, and no stored word changes.
- R2: A read command (`cmd_n`=0, `is_read`=1) at fast edge k drives beat 0 (bits DW-1:0 of the word) with `rvalid`=1 after edge k+3, and beat 1 (bits 2*DW-1:DW) after edge k+4.
- R3: A write command (`cmd_n`=0, `is_read`=0) at fast edge k stores the `wdata` sampled at edge k+2 as beat 0 and the `wdata` sampled at edge k+3 as beat 1 of the addressed word.
- R4: Outside the beats of a read, `rvalid` is 0 and `rdata` is all zeros.
- R5: Reads in consecutive command slots produce an unbroken stream of beats with `rvalid` held high.
- R6: A read in the slot right after a write to the same address returns the newly written beats.
- R7: A read in the slot right before a write to the same address returns the word held before that write.
- R8: `k_slot` is 1 during reset. After reset it alternates every fast cycle, and it is 1 exactly when the coming edge is a command slot.
- R9: During reset, `rvalid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, twice the command rate |
| rst | input | 1 | Synchronous reset, active high |
| k_slot | output | 1 | High when the next rising edge is a command slot |
| cmd_n | input | 1 | Command strobe, active low |
| is_read | input | 1 | 1 = read, 0 = write |
| addr | input | AW | Word address |
| wdata | input | DW | Write data beats |
| rdata | output | DW | Read data beats |
| rvalid | output | 1 | Read beat present (low = bus floating) |

## Verification
The hardest case to reach from the ports is the overlap of neighbouring commands. A write's two data beats share fast edges with the next command, and a read's beats share edges with the command after it. Ordering errors only show up when a read and a write to the same word sit in adjacent slots.

The driver issues one command per slot with no gaps. It feeds each write's beats on the following slot's edges and fills `wdata` with junk when no write is pending. It then places a read directly after a write, and a read directly before a write, to the same address. The scoreboard checks the exact fast-edge number of every beat.

// File: rtl/ddr_sio_b2.sv
module ddr_sio_b2 #(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  output logic          k_slot,
  input  logic          cmd_n,
  input  logic          is_read,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          rvalid
);
  localparam int DEPTH = 1 << AW;
  localparam int WW    = 2 * DW;

  logic          ph;
  logic          c_wr, c_rd, w_go, r_go, r_act;
  logic [AW-1:0] c_addr, w_addr, r_addr;
  logic [DW-1:0] w_lo, r_hi;
  logic [WW-1:0] mem [DEPTH];

  assign k_slot = ~ph;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph     <= 1'b0;
      c_wr   <= 1'b0;
      c_rd   <= 1'b0;
      c_addr <= '0;
      w_go   <= 1'b0;
      r_go   <= 1'b0;
      w_addr <= '0;
      r_addr <= '0;
      w_lo   <= '0;
      r_hi   <= '0;
      r_act  <= 1'b0;
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      ph <= ~ph;
      if (!ph) begin
        c_wr   <= ~cmd_n & ~is_read;
        c_rd   <= ~cmd_n &  is_read;
        c_addr <= addr;
        w_go   <= c_wr;
        w_addr <= c_addr;
        r_go   <= c_rd;
        r_addr <= c_addr;
        if (c_wr) w_lo <= wdata;
        rdata  <= r_act ? r_hi : '0;
        rvalid <= r_act;
      end else begin
        r_act  <= r_go;
        rvalid <= r_go;
        if (r_go) begin
          rdata <= mem[r_addr][DW-1:0];
          r_hi  <= mem[r_addr][WW-1:DW];
        end else begin
          rdata <= '0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst && ph && w_go) mem[w_addr] <= {wdata, w_lo};
  end

  // R8: command slots alternate with half slots
  p_phase_alt_r8: assert property (@(posedge clk) disable iff (rst)
    ph |=> !ph);

  // R4: a floating bus carries zeros
  p_idle_zero_r4: assert property (@(posedge clk) disable iff (rst)
    !rvalid |-> rdata == '0);

  // R2: a burst can only start on the half edge
  p_burst_start_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(rvalid) |-> !ph);

  // R2: beat 0 is always followed by beat 1
  p_beat_pair_r2: assert property (@(posedge clk) disable iff (rst)
    (rvalid && !ph) |=> rvalid);

  // R1: an idle slot yields no read beat
  p_idle_slot_r1: assert property (@(posedge clk) disable iff (rst)
    (!ph && cmd_n) |-> ##4 !rvalid);
endmodule

// File: tb/sim_ddr_sio_b2.sv
module sim_ddr_sio_b2;
  localparam int AW = 4;
  localparam int DW = 8;

  typedef struct {
    int            edge_no;
    logic [DW-1:0] d;
    string         tag;
  } item_t;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          k_slot, cmd_n, is_read, rvalid;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata, rdata;

  int errors = 0;
  int checks = 0;
  int cyc    = 0;
  bit done   = 0;

  item_t         q[$];
  logic [2*DW-1:0] model [1<<AW];
  bit            pend  = 0;
  logic [DW-1:0] p_lo, p_hi;

  ddr_sio_b2 #(.AW(AW), .DW(DW)) u0 (
    .clk(clk), .rst(rst), .k_slot(k_slot), .cmd_n(cmd_n), .is_read(is_read),
    .addr(addr), .wdata(wdata), .rdata(rdata), .rvalid(rvalid)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc = cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h (edge %0d)", tag, act, exp, cyc);
    end
  endtask

  // one command slot = two fast cycles; starts at a negedge with k_slot high
  task automatic slot(input bit ld_n, input bit rd, input logic [AW-1:0] a,
                      input logic [DW-1:0] lo, input logic [DW-1:0] hi, input string tag);
    int k;
    bit was_pend;
    logic [DW-1:0] plo, phi;
    k = cyc + 1;
    was_pend = pend; plo = p_lo; phi = p_hi;
    cmd_n = ld_n; is_read = rd; addr = a;
    wdata = was_pend ? plo : 8'hE5;
    if (!ld_n && rd) begin
      q.push_back('{k + 3, model[a][DW-1:0], tag});
      q.push_back('{k + 4, model[a][2*DW-1:DW], tag});
    end
    pend = 0;
    if (!ld_n && !rd) begin
      model[a] = {hi, lo};
      pend = 1; p_lo = lo; p_hi = hi;
    end
    @(negedge clk);
    cmd_n = 1'b1; is_read = ~rd; addr = ~a;
    wdata = was_pend ? phi : 8'h3C;
    @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      if (q.size() > 0 && q[0].edge_no == cyc) begin
        item_t it;
        it = q.pop_front();
        chk(rvalid === 1'b1, {it.tag, " valid"}, rvalid, 1);
        chk(rdata === it.d, {it.tag, " data"}, rdata, it.d);
      end else if (rvalid !== 1'b0) begin
        chk(0, "R4 unexpected beat", rvalid, 0);
      end
    end
  end

  initial begin
    cmd_n = 1'b1; is_read = 1'b0; addr = '0; wdata = '0;
    for (int i = 0; i < (1 << AW); i++) model[i] = 'x;
    repeat (3) @(negedge clk);
    chk(rvalid === 1'b0, "R9 reset valid", rvalid, 0);
    chk(k_slot === 1'b1, "R8 reset slot", k_slot, 1);
    rst = 1'b0;
    chk(k_slot === 1'b1, "R8 first slot", k_slot, 1);
    @(negedge clk);
    chk(k_slot === 1'b0, "R8 half slot", k_slot, 0);
    @(negedge clk);
    // R3: fill every word back to back
    for (int i = 0; i < (1 << AW); i++)
      slot(0, 0, i[AW-1:0], 8'(i * 7 + 1), 8'(i * 13 + 2), "R3");
    // R2/R5: back-to-back reads of every word
    for (int i = 0; i < (1 << AW); i++)
      slot(0, 1, i[AW-1:0], '0, '0, "R5");
    slot(1, 1, 0, '0, '0, "R4");
    slot(0, 0, 3, 8'h11, 8'h22, "R3");
    slot(0, 0, 5, 8'h33, 8'h44, "R3");
    slot(0, 1, 3, '0, '0, "R2");
    slot(0, 1, 5, '0, '0, "R5");
    // R1: idle slots with write select and junk data must not write
    slot(1, 0, 3, '0, '0, "R1");
    slot(1, 0, 5, '0, '0, "R1");
    slot(0, 1, 3, '0, '0, "R1");
    slot(0, 1, 5, '0, '0, "R1");
    // R6: read right after write to the same word
    slot(0, 0, 7, 8'h55, 8'h66, "R6");
    slot(0, 1, 7, '0, '0, "R6");
    // R7: read right before write to the same word
    slot(0, 1, 5, '0, '0, "R7");
    slot(0, 0, 5, 8'h77, 8'h88, "R7");
    slot(0, 1, 5, '0, '0, "R6");
    slot(1, 1, 0, '0, '0, "R4");
    slot(0, 1, 9, '0, '0, "R2");
    repeat (10) slot(1, 0, 0, '0, '0, "R4");
    chk(q.size() == 0, "R2 missing beats", q.size(), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule